// File: doc/BRIEF.md
# Selectable-Mapping Four-Line Tag Directory

This block tracks which memory blocks sit in a small cache of four lines. Each line has a valid flag and a stored tag. The block holds no data. A requester presents one block number per cycle, meaning a byte address with its two low offset bits already removed. One cycle later the block reports whether that block was present. On a miss the block is installed in a line. Two running counters record how many lookups were made and how many of them hit. Software can divide the two to get the hit ratio.

A parameter fixes the mapping at build time, with three choices:
- Direct mapping gives every block exactly one line.
- Two-way set mapping gives every block one set of two lines.
- Full association lets any block use any line, and all four tags are compared at once.

When a block may use more than one line, the choice of line follows two rules. An empty line in the target set is filled first. Otherwise a tree of recency bits picks the line that was not used recently.

The request side has no back-pressure. The directory can take a new block number on every clock, so there is no ready signal. Each valid request is answered by a single-cycle response strobe.

Top module: `cdir_top`

## Requirements
- R1: While reset is asserted, and after it is released, `rsp_valid` is 0, both counters are 0 and every line is invalid, so the first lookup of any block misses.
- R2: A request sampled with `req_valid`=1 at a clock edge produces `rsp_valid`=1 and its `rsp_hit` after that same edge. A cycle without a request leaves `rsp_valid`=0. A request is accepted on every cycle.
- R3: With `MAP_MODE`=0 (direct), a block maps to line `block mod 4`. A miss overwrites that line.
- R4: With `MAP_MODE`=1 (two-way), a block maps to set `block mod 2`, and the stored tag is `block >> 1`. Set s holds lines 2s and 2s+1 as ways 0 and 1. When both ways are valid, a miss replaces the way used less recently.
- R5: With `MAP_MODE`=2 (fully associative), any line may hold any block. Replacement uses three tree bits: p0 for the root, p1 for ways 0 and 1, and p2 for ways 2 and 3. Each bit holds 1 when its upper half was touched more recently. The victim is found by walking from the root toward the half whose bit says it is older.
- R6: A miss fills the lowest-numbered invalid way of the target set before it evicts any valid way.
- R7: Both a hit and an install make the touched way the most recently used. A block requested twice in a row therefore hits the second time.
- R8: `access_count` increases by 1 for each request, and `hit_count` increases by 1 for each hit. Both counters appear together with the response. Idle cycles change neither counter.
- R9: From reset, the sequence 0,4,0,8,0,8,0,4,0,4,0,4 gives 0 hits in 12 in direct mode, 8 in 12 in two-way mode and 9 in 12 in fully associative mode.
- R10: From reset in direct mode, the sequence 0,7,9,10 repeated three times gives 8 hits in 12.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | A block number is presented this cycle |
| req_block | input | BLK_W | Block number (byte address without the line offset) |
| rsp_valid | output | 1 | Response strobe, one cycle after a request |
| rsp_hit | output | 1 | 1 when the requested block was present |
| hit_count | output | CNT_W | Number of hits since reset |
| access_count | output | CNT_W | Number of requests since reset |

## Verification
The bench builds three copies at once, with `MAP_MODE` set to 0, 1 and 2, keeping four lines and 8-bit block numbers. All three copies receive the same stream, so the same stream can show different outcomes under each mapping. Running the fixed reference sequences this way reaches the eviction, invalid-first fill and recency-tree paths side by side. A seeded random stream then uses block numbers from a range of twelve, which forces conflict misses in every mode. Idle gaps in that stream expose the counter-hold and response-strobe rules.

// File: rtl/cdir_pkg.sv
package cdir_pkg;
  localparam int MAP_DIRECT = 0;
  localparam int MAP_TWOWAY = 1;
  localparam int MAP_FULL   = 2;

  function automatic int ways_for(input int mode, input int lines);
    if (mode == MAP_DIRECT) return 1;
    if (mode == MAP_TWOWAY) return 2;
    return lines;
  endfunction
endpackage

// File: rtl/cdir_match.sv
module cdir_match #(
  parameter int WAYS  = 2,
  parameter int TAG_W = 7,
  localparam int WW   = (WAYS > 1) ? $clog2(WAYS) : 1
) (
  input  logic [WAYS-1:0]       valid_i,
  input  logic [WAYS*TAG_W-1:0] tags_i,
  input  logic [TAG_W-1:0]      tag_i,
  output logic                  hit_o,
  output logic [WW-1:0]         hit_way_o,
  output logic                  free_o,
  output logic [WW-1:0]         free_way_o
);
  logic [WAYS-1:0] eq;

  for (genvar w = 0; w < WAYS; w++) begin : g_cmp
    assign eq[w] = valid_i[w] && (tags_i[w*TAG_W +: TAG_W] == tag_i);
  end

  always_comb begin
    hit_o      = 1'b0;
    hit_way_o  = '0;
    free_o     = 1'b0;
    free_way_o = '0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (eq[w]) begin
        hit_o     = 1'b1;
        hit_way_o = WW'(w);
      end
      if (!valid_i[w]) begin
        free_o     = 1'b1;
        free_way_o = WW'(w);
      end
    end
  end
endmodule

// File: rtl/cdir_plru.sv
module cdir_plru #(
  parameter int WAYS = 2,
  localparam int WW  = (WAYS > 1) ? $clog2(WAYS) : 1,
  localparam int PW  = (WAYS > 1) ? WAYS - 1 : 1
) (
  input  logic [PW-1:0] state_i,
  input  logic [WW-1:0] touch_i,
  output logic [WW-1:0] victim_o,
  output logic [PW-1:0] state_o
);
  if (WAYS > 1) begin : g_tree
    localparam int LV = $clog2(WAYS);
    always_comb begin
      int node;
      int vi;
      node = 0;
      vi   = 0;
      for (int l = 0; l < LV; l++) begin
        // bit=1: upper half newer, so walk to the lower half
        if (state_i[node]) begin
          vi   = vi * 2;
          node = 2 * node + 1;
        end else begin
          vi   = vi * 2 + 1;
          node = 2 * node + 2;
        end
      end
      victim_o = WW'(vi);
    end

    always_comb begin
      int node;
      state_o = state_i;
      node    = 0;
      for (int l = 0; l < LV; l++) begin
        state_o[node] = touch_i[LV-1-l];
        node = 2 * node + 1 + int'(touch_i[LV-1-l]);
      end
    end
  end else begin : g_single
    assign victim_o = '0;
    assign state_o  = state_i;
  end
endmodule

// File: rtl/cdir_top.sv
module cdir_top #(
  parameter int LINES    = 4,
  parameter int MAP_MODE = cdir_pkg::MAP_TWOWAY,
  parameter int BLK_W    = 8,
  parameter int CNT_W    = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic [BLK_W-1:0] req_block,
  output logic             rsp_valid,
  output logic             rsp_hit,
  output logic [CNT_W-1:0] hit_count,
  output logic [CNT_W-1:0] access_count
);
  localparam int WAYS  = cdir_pkg::ways_for(MAP_MODE, LINES);
  localparam int SETS  = LINES / WAYS;
  localparam int IDXB  = $clog2(SETS);
  localparam int IDX_W = (SETS > 1) ? IDXB : 1;
  localparam int TAG_W = BLK_W - IDXB;
  localparam int WW    = (WAYS > 1) ? $clog2(WAYS) : 1;
  localparam int PW    = (WAYS > 1) ? WAYS - 1 : 1;
  localparam int LW    = (LINES > 1) ? $clog2(LINES) : 1;

  logic [LINES-1:0] valid_q;
  logic [TAG_W-1:0] tag_q [LINES];
  logic [PW-1:0]    plru_q [SETS];

  logic [IDX_W-1:0]      set_idx;
  logic [TAG_W-1:0]      req_tag;
  logic [WAYS-1:0]       set_valid;
  logic [WAYS*TAG_W-1:0] set_tags;
  logic [PW-1:0]         set_plru;
  logic                  hit, free;
  logic [WW-1:0]         hit_way, free_way, victim_way, fill_way, touch_way;
  logic [PW-1:0]         plru_next;
  logic [LW-1:0]         fill_line;

  assign set_idx = IDX_W'(int'(req_block) % SETS);
  assign req_tag = TAG_W'(req_block >> IDXB);

  always_comb begin
    for (int w = 0; w < WAYS; w++) begin
      set_valid[w]                = valid_q[int'(set_idx) * WAYS + w];
      set_tags[w*TAG_W +: TAG_W]  = tag_q[int'(set_idx) * WAYS + w];
    end
    set_plru = plru_q[int'(set_idx)];
  end

  cdir_match #(.WAYS(WAYS), .TAG_W(TAG_W)) match_i (
    .valid_i    (set_valid),
    .tags_i     (set_tags),
    .tag_i      (req_tag),
    .hit_o      (hit),
    .hit_way_o  (hit_way),
    .free_o     (free),
    .free_way_o (free_way)
  );

  assign fill_way  = free ? free_way : victim_way;
  assign touch_way = hit ? hit_way : fill_way;
  assign fill_line = LW'(int'(set_idx) * WAYS + int'(fill_way));

  cdir_plru #(.WAYS(WAYS)) plru_i (
    .state_i  (set_plru),
    .touch_i  (touch_way),
    .victim_o (victim_way),
    .state_o  (plru_next)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q      <= '0;
      rsp_valid    <= 1'b0;
      rsp_hit      <= 1'b0;
      hit_count    <= '0;
      access_count <= '0;
      for (int s = 0; s < SETS; s++) plru_q[s] <= '0;
    end else begin
      rsp_valid <= req_valid;
      if (req_valid) begin
        rsp_hit      <= hit;
        access_count <= access_count + 1'b1;
        if (hit) hit_count <= hit_count + 1'b1;
        else     valid_q[fill_line] <= 1'b1;
        plru_q[int'(set_idx)] <= plru_next;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (req_valid && !hit) tag_q[fill_line] <= req_tag;
  end
endmodule

// File: rtl/cdir_checker.sv
module cdir_checker #(
  parameter int BLK_W = 8,
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_valid,
  input logic [BLK_W-1:0] req_block,
  input logic             rsp_valid,
  input logic             rsp_hit,
  input logic [CNT_W-1:0] hit_count,
  input logic [CNT_W-1:0] access_count
);
  a_r1_reset_clear: assert property (@(posedge clk)
    !rst_n |-> (!rsp_valid && hit_count == '0 && access_count == '0));

  a_r2_rsp_follows: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);

  a_r2_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !rsp_valid);

  a_r8_access_step: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> access_count == $past(access_count) + 1'b1);

  a_r8_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> ($stable(access_count) && $stable(hit_count)));

  a_r8_hit_step: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_hit) |-> hit_count == $past(hit_count) + 1'b1);

  a_r7_repeat_hits: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && $past(req_valid) && $past(rst_n) && req_block == $past(req_block))
      |=> rsp_hit);
endmodule

bind cdir_top cdir_checker #(.BLK_W(BLK_W), .CNT_W(CNT_W)) chk_i (.*);

// File: tb/cdir_top_tb_top.sv
module cdir_top_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic [7:0] req_block = '0;
  logic [2:0] rv, rh;
  logic [15:0] hc [3];
  logic [15:0] ac [3];

  always #5 clk = ~clk;

  cdir_top #(.MAP_MODE(0)) dut_dm_i (.clk, .rst_n, .req_valid, .req_block,
    .rsp_valid(rv[0]), .rsp_hit(rh[0]), .hit_count(hc[0]), .access_count(ac[0]));
  cdir_top #(.MAP_MODE(1)) dut_i (.clk, .rst_n, .req_valid, .req_block,
    .rsp_valid(rv[1]), .rsp_hit(rh[1]), .hit_count(hc[1]), .access_count(ac[1]));
  cdir_top #(.MAP_MODE(2)) dut_fa_i (.clk, .rst_n, .req_valid, .req_block,
    .rsp_valid(rv[2]), .rsp_hit(rh[2]), .hit_count(hc[2]), .access_count(ac[2]));

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  bit        mv [3][4];
  int        mb [3][4];
  bit [2:0]  mp [3][4];
  bit        pend_v;
  bit        pend_h [3];
  int        e_acc [3];
  int        e_hit [3];

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic void model_reset();
    for (int m = 0; m < 3; m++) begin
      for (int l = 0; l < 4; l++) begin mv[m][l] = 0; mb[m][l] = 0; mp[m][l] = 0; end
      e_acc[m] = 0; e_hit[m] = 0; pend_h[m] = 0;
    end
    pend_v = 0;
  endfunction

  function automatic bit model_step(input int m, input int blk);
    int sets, ways, s, way, found;
    sets = (m == 0) ? 4 : (m == 1) ? 2 : 1;
    ways = 4 / sets;
    s = blk % sets;
    found = -1;
    for (int w = 0; w < ways; w++)
      if (found < 0 && mv[m][s*ways+w] && mb[m][s*ways+w] == blk) found = w;
    if (found >= 0) way = found;
    else begin
      way = -1;
      for (int w = 0; w < ways; w++) if (way < 0 && !mv[m][s*ways+w]) way = w;
      if (way < 0) begin
        if (ways == 1) way = 0;
        else if (ways == 2) way = mp[m][s][0] ? 0 : 1;
        else begin
          int d1, d2;
          d1 = mp[m][s][0] ? 0 : 1;
          d2 = mp[m][s][1 + d1] ? 0 : 1;
          way = d1 * 2 + d2;
        end
      end
      mv[m][s*ways+way] = 1;
      mb[m][s*ways+way] = blk;
    end
    if (ways == 2) mp[m][s][0] = way[0];
    else if (ways == 4) begin
      mp[m][s][0] = way[1];
      mp[m][s][1 + way[1]] = way[0];
    end
    return found >= 0;
  endfunction

  task automatic cyc(input bit v, input int blk);
    for (int m = 0; m < 3; m++) begin
      chk(rv[m] == pend_v, "R2 rsp_valid", int'(rv[m]), int'(pend_v));
      if (pend_v) chk(rh[m] == pend_h[m], "R3/R4/R5/R6/R7 rsp_hit", int'(rh[m]), int'(pend_h[m]));
      chk(int'(ac[m]) == e_acc[m], "R8 access_count", int'(ac[m]), e_acc[m]);
      chk(int'(hc[m]) == e_hit[m], "R8 hit_count", int'(hc[m]), e_hit[m]);
    end
    req_valid = v;
    req_block = 8'(blk);
    pend_v = v;
    if (v) for (int m = 0; m < 3; m++) begin
      pend_h[m] = model_step(m, blk);
      e_acc[m]++;
      if (pend_h[m]) e_hit[m]++;
    end
    @(negedge clk);
  endtask

  task automatic do_reset();
    req_valid = 0;
    rst_n = 0;
    @(negedge clk);
    model_reset();
    for (int m = 0; m < 3; m++)
      chk(!rv[m] && ac[m] == 0 && hc[m] == 0, "R1 reset state", int'(ac[m]), 0);
    @(negedge clk);
    rst_n = 1;
    @(negedge clk);
  endtask

  initial begin
    int pat1 [12] = '{0,4,0,8,0,8,0,4,0,4,0,4};
    int pat2 [4]  = '{0,7,9,10};
    void'($urandom(32'd1234));
    do_reset();
    // R1: first lookups after reset all miss
    cyc(1, 5); cyc(1, 6); cyc(0, 0);
    for (int m = 0; m < 3; m++) chk(hc[m] == 0, "R1 first lookup misses", int'(hc[m]), 0);

    do_reset();
    for (int i = 0; i < 12; i++) cyc(1, pat1[i]);
    cyc(0, 0);
    chk(hc[0] == 0, "R9 direct hits", int'(hc[0]), 0);
    chk(hc[1] == 8, "R9 two-way hits", int'(hc[1]), 8);
    chk(hc[2] == 9, "R9 full hits", int'(hc[2]), 9);
    chk(ac[2] == 12, "R9 accesses", int'(ac[2]), 12);

    do_reset();
    for (int r = 0; r < 3; r++) for (int i = 0; i < 4; i++) cyc(1, pat2[i]);
    cyc(0, 0);
    chk(hc[0] == 8, "R10 direct hits", int'(hc[0]), 8);

    // R6: full mode fills 4 distinct blocks, then all hit
    do_reset();
    for (int i = 0; i < 4; i++) cyc(1, 16 + i);
    for (int i = 0; i < 4; i++) cyc(1, 16 + i);
    cyc(0, 0);
    chk(hc[2] == 4, "R6 full invalid-first", int'(hc[2]), 4);

    // R5: tree victim after fill 0..3, touch 0 -> evict way 2 (block 2)
    do_reset();
    for (int i = 0; i < 4; i++) cyc(1, i);
    cyc(1, 0); cyc(1, 9); cyc(1, 2); cyc(0, 0);
    chk(rh[2] == 0, "R5 victim choice", int'(rh[2]), 0);

    do_reset();
    for (int i = 0; i < 600; i++) begin
      bit v;
      v = ($urandom % 5) != 0;
      cyc(v, int'($urandom % 12));
    end
    cyc(0, 0); cyc(0, 0);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule